// File: doc/BRIEF.md
# Fractional-Resolution Double-Buffered PWM Generator

This block produces a pulse-width modulated output whose duty cycle has ten bits of resolution while its period timer is only eight bits wide. The timer is stretched by a two-bit sub-count taken from a fine counter that runs below it. With a prescale of one, that sub-count is a free-running divide-by-four phase. With a prescale of four or sixteen, it is the two upper bits of the prescaler. The duty value is compared against the timer joined with the sub-count, so one duty step lasts one clock times the prescale.

Software writes the duty value as an eight-bit upper part and a two-bit lower part, and may do so at any time. The combined value is moved into a shadow register only at the end of a period. The waveform therefore changes only on period boundaries and never shows a partial or glitched pulse. The shadow value can be read back on a dedicated output.

Top module: `pwm_frac`

## Requirements
- R1: The duty value is {duty_hi_i, duty_lo_i}: duty_hi_i supplies bits 9..2 and duty_lo_i supplies bits 1..0. shadow_o shows the duty value most recently loaded, in the same bit order.
- R2: shadow_o takes the duty inputs only on the clock edge that ends a period. A duty write at any other time changes neither shadow_o nor pwm_o before the next period end.
- R3: A period lasts (period_i + 1) × 4 × PS clocks. PS is set by pre_sel_i: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 gives 16.
- R4: In a period that starts with shadow value D, pwm_o is high for the first D × PS clocks of the period and low for the rest.
- R5: A loaded duty value of zero keeps pwm_o low for the whole period.
- R6: A duty value larger than the largest extended count, (period_i + 1) × 4 − 1, keeps pwm_o high for the whole period, with no low cycle at the period boundary.
- R7: Reset sets shadow_o to 0 and holds pwm_o low. One clock after pwm_en goes low, pwm_o is low and all counters are cleared. shadow_o keeps its value while the block is disabled.
- R8: After pwm_en rises, counting starts from zero. pwm_o stays low for the whole first period, and the first shadow load happens at the end of that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_en | input | 1 | Enables counting and output |
| period_i | input | 8 | Terminal timer value; the period ends when the timer reaches it |
| pre_sel_i | input | 2 | Prescale select (1, 4 or 16) |
| duty_hi_i | input | 8 | Upper eight bits of the duty value |
| duty_lo_i | input | 2 | Lower two bits of the duty value |
| pwm_o | output | 1 | PWM output |
| shadow_o | output | 10 | Duty value currently in effect |

## Verification
Both outputs are registered, so each result appears one clock after the edge that causes it. After pwm_en rises, the first period end falls on the N-th rising edge, where N = (period_i + 1) × 4 × PS, and the new shadow value and the rising pin appear right after that edge. Clearing on disable is visible one edge after pwm_en falls. A driver derives the expected pin and shadow state for the k-th edge from these rules and queues it 1 ns after that edge. A monitor then compares the queued state at the following falling edge. Duty writes are made in the middle of a period to show that they take effect only at the next period end.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;

   // Largest prescale is 2**PS_LOG_MAX clocks per fine step group
   localparam int PS_LOG_MAX = 4;

   typedef enum logic [1:0] {
      PS_DIV1   = 2'b00,
      PS_DIV4   = 2'b01,
      PS_DIV16  = 2'b10,
      PS_DIV16B = 2'b11
   } ps_sel_e;

   // log2 of the prescale for a select code
   function automatic int ps_log2(input int code);
      case (code)
         0:       return 0;
         1:       return 2;
         default: return PS_LOG_MAX;
      endcase
   endfunction

endpackage

// File: rtl/pwm_frac_timebase.sv
module pwm_frac_timebase #(
   parameter int CNT_W = 8,
   parameter int SUB_W = 2,
   localparam int EXT_W  = CNT_W + SUB_W,
   localparam int FINE_W = SUB_W + pwm_frac_pkg::PS_LOG_MAX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] period,
   input  logic [1:0]       pre_sel,
   output logic [EXT_W-1:0] ext_cnt,
   output logic [EXT_W-1:0] ext_nxt,
   output logic             wrap
);

   logic [FINE_W-1:0] fine_q, fine_n;
   logic [CNT_W-1:0]  tmr_q, tmr_n;
   logic [FINE_W-1:0] opt_last  [4];
   logic [SUB_W-1:0]  opt_sub_q [4];
   logic [SUB_W-1:0]  opt_sub_n [4];
   logic              fine_end, tmr_end;

   // One variant per prescale code: terminal fine value and sub-count slice
   for (genvar gi = 0; gi < 4; gi++) begin : g_ps
      localparam int PL = pwm_frac_pkg::ps_log2(gi);
      assign opt_last[gi]  = FINE_W'((1 << (SUB_W + PL)) - 1);
      assign opt_sub_q[gi] = SUB_W'(fine_q >> PL);
      assign opt_sub_n[gi] = SUB_W'(fine_n >> PL);
   end

   // Terminal compares use >= so a shrinking limit cannot strand a counter
   assign fine_end = (fine_q >= opt_last[pre_sel]);
   assign tmr_end  = (tmr_q >= period);
   assign wrap     = en & fine_end & tmr_end;

   always_comb begin
      fine_n = '0;
      tmr_n  = '0;
      if (en) begin
         if (fine_end) begin
            fine_n = '0;
            tmr_n  = tmr_end ? '0 : tmr_q + 1'b1;
         end else begin
            fine_n = fine_q + 1'b1;
            tmr_n  = tmr_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fine_q <= '0;
         tmr_q  <= '0;
      end else begin
         fine_q <= fine_n;
         tmr_q  <= tmr_n;
      end
   end

   assign ext_cnt = {tmr_q, opt_sub_q[pre_sel]};
   assign ext_nxt = {tmr_n, opt_sub_n[pre_sel]};

endmodule

// File: rtl/pwm_frac_dbuf.sv
module pwm_frac_dbuf #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DUTY_W-1:0] duty_in,
   output logic [DUTY_W-1:0] shadow_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow_q <= '0;
      else if (load)
         shadow_q <= duty_in;
   end

endmodule

// File: rtl/pwm_frac_outstage.sv
module pwm_frac_outstage #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic [DUTY_W-1:0] duty_in,
   input  logic [DUTY_W-1:0] shadow_q,
   input  logic [DUTY_W-1:0] ext_nxt,
   output logic              pin_q
);

   logic pin_n;

   // Set at period start unless the new duty is zero; clear on match
   always_comb begin
      if (!en)
         pin_n = 1'b0;
      else if (load)
         pin_n = |duty_in;
      else if (ext_nxt == shadow_q)
         pin_n = 1'b0;
      else
         pin_n = pin_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_q <= 1'b0;
      else
         pin_q <= pin_n;
   end

endmodule

// File: rtl/pwm_frac.sv
module pwm_frac #(
   parameter int CNT_W = 8,
   parameter int SUB_W = 2,
   localparam int EXT_W = CNT_W + SUB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_en,
   input  logic [CNT_W-1:0] period_i,
   input  logic [1:0]       pre_sel_i,
   input  logic [CNT_W-1:0] duty_hi_i,
   input  logic [SUB_W-1:0] duty_lo_i,
   output logic             pwm_o,
   output logic [EXT_W-1:0] shadow_o
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("pwm_frac: CNT_W must be at least 2");
   end
   if (SUB_W < 1 || SUB_W > 4) begin : g_bad_sub
      $error("pwm_frac: SUB_W must lie in 1..4");
   end

   logic [EXT_W-1:0] ext_cnt, ext_nxt, duty_new;
   logic             wrap;

   assign duty_new = {duty_hi_i, duty_lo_i};

   pwm_frac_timebase #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (pwm_en),
      .period  (period_i),
      .pre_sel (pre_sel_i),
      .ext_cnt (ext_cnt),
      .ext_nxt (ext_nxt),
      .wrap    (wrap)
   );

   pwm_frac_dbuf #(.DUTY_W(EXT_W)) u_dbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wrap),
      .duty_in  (duty_new),
      .shadow_q (shadow_o)
   );

   pwm_frac_outstage #(.DUTY_W(EXT_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (pwm_en),
      .load     (wrap),
      .duty_in  (duty_new),
      .shadow_q (shadow_o),
      .ext_nxt  (ext_nxt),
      .pin_q    (pwm_o)
   );

endmodule

// File: rtl/pwm_frac_chk.sv
module pwm_frac_chk #(
   parameter int EXT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             load,
   input logic [EXT_W-1:0] ext_cnt,
   input logic [EXT_W-1:0] shadow,
   input logic             pin
);

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(shadow)); // R2

   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ext_cnt == '0)); // R3

   AST_PIN_BELOW_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      pin |-> (ext_cnt < shadow)); // R4

   AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin) |-> $past(load)); // R4

   AST_OFF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pin && ext_cnt == '0)); // R7

endmodule

bind pwm_frac pwm_frac_chk #(.EXT_W(CNT_W + SUB_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (pwm_en),
   .load    (wrap),
   .ext_cnt (ext_cnt),
   .shadow  (shadow_o),
   .pin     (pwm_o)
);

// File: tb/pwm_frac_tb.sv
`timescale 1ns/1ps
module pwm_frac_tb;

   typedef struct {
      logic       pin;
      logic [9:0] shd;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_en = 1'b0;
   logic [7:0] period_i = '0;
   logic [1:0] pre_sel_i = '0;
   logic [7:0] duty_hi_i = '0;
   logic [1:0] duty_lo_i = '0;
   logic       pwm_o;
   logic [9:0] shadow_o;

   int   total = 0;
   int   bad = 0;
   logic [9:0] shadow_model = '0;
   exp_t q[$];

   always #2 clk = ~clk;

   pwm_frac u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwm_en    (pwm_en),
      .period_i  (period_i),
      .pre_sel_i (pre_sel_i),
      .duty_hi_i (duty_hi_i),
      .duty_lo_i (duty_lo_i),
      .pwm_o     (pwm_o),
      .shadow_o  (shadow_o)
   );

   // Monitor: compare queued expectations at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         total++;
         if (pwm_o !== it.pin || shadow_o !== it.shd) begin
            bad++;
            $display("FAIL %s: pin act=%0b exp=%0b shadow act=%h exp=%h",
                     it.tag, pwm_o, it.pin, shadow_o, it.shd);
         end
      end
   end

   function automatic void push(input logic p, input logic [9:0] s, input string t);
      exp_t it;
      it.pin = p;
      it.shd = s;
      it.tag = t;
      q.push_back(it);
   endfunction

   // Driver: called 1 ns after a rising edge
   task automatic run_case(input string tag, input int per, input int sel,
                           input int duty, input int nclk,
                           input int chg_at, input int duty2);
      int ps;
      int n;
      logic [9:0] drv;
      logic [9:0] cur;
      ps  = (sel == 0) ? 1 : (sel == 1) ? 4 : 16;       // R3 prescale codes
      n   = (per + 1) * 4 * ps;
      drv = 10'(duty);
      cur = shadow_model;
      period_i  = 8'(per);
      pre_sel_i = 2'(sel);
      {duty_hi_i, duty_lo_i} = drv;                     // R1 bit split
      pwm_en = 1'b1;
      for (int k = 1; k <= nclk; k++) begin
         int c;
         @(posedge clk);
         #1;
         c = k % n;
         if (c == 0) cur = drv;                          // R2 load at period end
         push((k >= n) && ((c / ps) < int'(cur)), cur, tag); // R4 R8
         if (k == chg_at) begin
            drv = 10'(duty2);
            {duty_hi_i, duty_lo_i} = drv;
         end
      end
      pwm_en = 1'b0;
      @(posedge clk);
      #1;
      push(1'b0, cur, {tag, " R7 off"});
      shadow_model = cur;
      @(posedge clk);
      #1;
      push(1'b0, cur, {tag, " R7 off"});
   endtask

   initial begin
      #1000000;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (pwm_o !== 1'b0 || shadow_o !== 10'h000) begin
         bad++;
         $display("FAIL R7 reset: pin act=%0b exp=0 shadow act=%h exp=000", pwm_o, shadow_o);
      end
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      run_case("R1 R2 R4", 8'hFF, 0, 512, 3080, 1500, 10'h0C5);
      run_case("R3 base8", 8'h3F, 0, 10'h055, 600, 0, 0);
      run_case("R3 R4 ps4", 8'h07, 1, 13, 400, 0, 0);
      run_case("R3 R4 ps16", 8'h03, 2, 5, 800, 0, 0);
      run_case("R3 ps16b", 8'h01, 3, 7, 300, 0, 0);
      run_case("R5 R6", 8'h0F, 0, 0, 200, 100, 10'h3FF);
      run_case("R6 edge", 8'h0F, 0, 64, 200, 100, 63);
      run_case("R7 midstop", 8'h0F, 0, 20, 100, 0, 0);
      run_case("R8 restart", 8'h0F, 0, 40, 70, 0, 0);
      repeat (3) @(posedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule